// File: doc/BRIEF.md
# ADC Start-of-Conversion Arbiter with One-Shot Gating

This block sequences requests for a shared analog-to-digital converter. There are sixteen request slots. Each slot selects one trigger source from a common pool of event lines: three timer events, an external pin, the A and B conversion-start lines of nine PWM units, and two converter interrupt lines fed back so that conversions can run as a continuous stream. A per-slot software force line also triggers its slot. A trigger latches a pending flag for its slot. The arbiter chooses which pending slot the converter serves next.

A split value P divides the slots into two groups. Slots below P form a fixed-priority group, and the lowest index wins there. Slots from P upward form a round-robin wheel, which is searched starting one above the wheel pointer. When one-shot mode is on, only one wheel slot may latch a request: the slot one step past the pointer, or two steps past it when the slot at the pointer samples a channel pair. Triggers to every other wheel slot are dropped. The fixed-priority group is never restricted by one-shot mode.

The converter is modelled as a start strobe and a done pulse. The block issues one strobe, then waits for the done pulse before it arbitrates again. Along with the strobe it presents the granted slot and that slot's channel, or its channel pair.

Top module: `adc_soc_sequencer`

## Requirements
- R1: While reset is held, pending and overflow are all zero, start_strobe is low, and rr_ptr is 15.
- R2: A slot's trigger select picks its source with this encoding: 0 = none, 1..3 = timer_evt[0..2], 4 = ext_trig, 5+2k = pwm_soca[k] and 6+2k = pwm_socb[k] for k = 0..8, 23..24 = irq_fb[0..1], and 25..31 = none. sw_force[s] triggers slot s whatever its select is. A trigger sampled at a clock edge shows in pending after that edge.
- R3: A trigger that is accepted for a slot whose flag is already pending, and which is not being granted in that same cycle, sets that slot's overflow bit. No extra conversion is queued for it. Overflow bits are sticky until reset.
- R4: Slots with an index below prio_split (0..16) are the high-priority group. The lowest pending index in that group is granted, and it wins over every wheel slot.
- R5: Slots at or above prio_split form the wheel. When no high-priority slot is pending, the grant goes to the first pending wheel slot found searching upward from rr_ptr+1, wrapping from 15 to 0. A wheel grant sets rr_ptr to the granted slot. A high-priority grant leaves rr_ptr unchanged.
- R6: grant_chan is the slot's 4-bit channel field when the slot's simultaneous flag is 0. When the flag is 1, grant_chan is {0, low 3 bits of the field}, a pair index, and grant_simul is 1.
- R7: start_strobe is a one-cycle pulse. It rises the cycle after an edge at which the block is idle and some flag is pending. No further strobe comes until a conv_done has been sampled, and the next strobe can come at the earliest one cycle after that sample. conv_done while idle is ignored.
- R8: With oneshot_en high, the only wheel slot that can latch a trigger is the target. The target is found by stepping from rr_ptr to the next wheel slot: step up by one, and if the result passes 15 or falls below prio_split, go to prio_split. Accepted triggers to other wheel slots leave pending and overflow unchanged.
- R9: With oneshot_en high and the slot at rr_ptr flagged simultaneous, the target is two such steps from rr_ptr.
- R10: Slots in the high-priority group latch triggers whatever the value of oneshot_en.
- R11: A grant clears the granted slot's pending flag. A trigger for that slot sampled at the same edge latches it again without setting overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oneshot_en | input | 1 | Restricts wheel triggers to the one-shot target |
| prio_split | input | 5 | Number of high-priority slots (0..16) |
| cfg_trig_sel | input | 80 | Trigger select per slot, 5 bits each, slot s at [5s+4:5s] |
| cfg_chan | input | 64 | Channel field per slot, 4 bits each |
| cfg_simul | input | 16 | Simultaneous-sampling flag per slot |
| sw_force | input | 16 | Software trigger per slot |
| timer_evt | input | 3 | Timer event pulses |
| ext_trig | input | 1 | External pin trigger |
| pwm_soca | input | 9 | PWM conversion-start A lines |
| pwm_socb | input | 9 | PWM conversion-start B lines |
| irq_fb | input | 2 | Converter interrupt lines fed back as triggers |
| conv_done | input | 1 | Converter finished the current conversion |
| start_strobe | output | 1 | One-cycle start pulse to the converter |
| grant_slot | output | 4 | Slot granted by the latest strobe |
| grant_chan | output | 4 | Channel, or pair index, of the granted slot |
| grant_simul | output | 1 | Granted slot samples a channel pair |
| pending | output | 16 | Pending flags |
| overflow | output | 16 | Sticky overflow flags |
| rr_ptr | output | 4 | Round-robin wheel pointer |

## Verification
A trigger sampled at edge k shows in pending after edge k. If the block is idle, the strobe, the grant fields and the moved pointer all show after edge k+1. A conv_done sampled at edge d allows the next strobe after edge d+1. The bench drives inputs on the falling edge. Its reference model steps once for each rising edge, using the inputs presented and its state from before that edge. Every output is compared on the next falling edge, so every result is checked in exactly the cycle it is due.

// File: rtl/adc_soc_pkg.sv
package adc_soc_pkg;
  parameter int SOC_SLOTS  = 16;
  parameter int SEL_W      = 5;
  parameter int CHAN_W     = 4;
  parameter int NUM_TIMERS = 3;
  parameter int NUM_PWM    = 9;
  parameter int NUM_FB     = 2;

  localparam int SLOT_W    = $clog2(SOC_SLOTS);
  localparam int PRIO_W    = SLOT_W + 1;
  localparam int SRC_TMR0  = 1;
  localparam int SRC_EXT   = SRC_TMR0 + NUM_TIMERS;
  localparam int SRC_PWM0  = SRC_EXT + 1;
  localparam int SRC_FB0   = SRC_PWM0 + 2 * NUM_PWM;
  localparam int NUM_SRC   = SRC_FB0 + NUM_FB;
  localparam int SRC_VEC_W = 1 << SEL_W;

  typedef logic [SLOT_W-1:0]    slot_t;
  typedef logic [SOC_SLOTS-1:0] slot_vec_t;
  typedef logic [PRIO_W-1:0]    prio_t;
  typedef logic [CHAN_W-1:0]    chan_t;

  typedef struct packed {
    logic  valid;
    slot_t slot;
    logic  wheel;
  } pick_t;

  function automatic logic in_wheel(slot_t s, prio_t split);
    return {1'b0, s} >= split;
  endfunction

  // one step along the wheel: up by one, fold to the first wheel slot
  function automatic slot_t wheel_adv(slot_t p, prio_t split);
    prio_t x;
    x = {1'b0, p} + prio_t'(1);
    if (x > prio_t'(SOC_SLOTS - 1) || x < split) x = split;
    return x[SLOT_W-1:0];
  endfunction

  function automatic slot_t oneshot_target(slot_t p, prio_t split, slot_vec_t simul);
    slot_t t;
    t = wheel_adv(p, split);
    if (simul[p]) t = wheel_adv(t, split);
    return t;
  endfunction

  function automatic pick_t prio_pick(slot_vec_t pend, prio_t split);
    pick_t r;
    r = '0;
    for (int i = SOC_SLOTS - 1; i >= 0; i--) begin
      if (pend[i] && !in_wheel(slot_t'(i), split)) begin
        r.valid = 1'b1;
        r.slot  = slot_t'(i);
      end
    end
    return r;
  endfunction

  function automatic pick_t rr_pick(slot_vec_t pend, prio_t split, slot_t p);
    pick_t r;
    slot_t idx;
    r = '0;
    for (int i = SOC_SLOTS; i >= 1; i--) begin
      idx = slot_t'(int'(p) + i);
      if (pend[idx] && in_wheel(idx, split)) begin
        r.valid = 1'b1;
        r.slot  = idx;
        r.wheel = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic chan_t chan_out(chan_t field, logic simul);
    return simul ? {1'b0, field[CHAN_W-2:0]} : field;
  endfunction
endpackage

// File: rtl/soc_trig_router.sv
module soc_trig_router
  import adc_soc_pkg::*;
(
  input  logic [SOC_SLOTS*SEL_W-1:0] cfg_trig_sel,
  input  slot_vec_t                  sw_force,
  input  logic [NUM_TIMERS-1:0]      timer_evt,
  input  logic                       ext_trig,
  input  logic [NUM_PWM-1:0]         pwm_soca,
  input  logic [NUM_PWM-1:0]         pwm_socb,
  input  logic [NUM_FB-1:0]          irq_fb,
  output slot_vec_t                  trig_vec
);
  logic [SRC_VEC_W-1:0] src_vec;

  always_comb begin
    src_vec = '0;
    src_vec[SRC_TMR0 +: NUM_TIMERS] = timer_evt;
    src_vec[SRC_EXT] = ext_trig;
    for (int k = 0; k < NUM_PWM; k++) begin
      src_vec[SRC_PWM0 + 2*k]     = pwm_soca[k];
      src_vec[SRC_PWM0 + 2*k + 1] = pwm_socb[k];
    end
    src_vec[SRC_FB0 +: NUM_FB] = irq_fb;
  end

  for (genvar s = 0; s < SOC_SLOTS; s++) begin : g_slot
    logic [SEL_W-1:0] sel;
    assign sel         = cfg_trig_sel[s*SEL_W +: SEL_W];
    assign trig_vec[s] = sw_force[s] | src_vec[sel];
  end
endmodule

// File: rtl/soc_oneshot_gate.sv
module soc_oneshot_gate
  import adc_soc_pkg::*;
(
  input  logic      oneshot_en,
  input  prio_t     prio_split,
  input  slot_t     rr_ptr,
  input  slot_vec_t cfg_simul,
  output slot_t     target,
  output slot_vec_t elig_vec
);
  assign target = oneshot_target(rr_ptr, prio_split, cfg_simul);

  for (genvar s = 0; s < SOC_SLOTS; s++) begin : g_elig
    assign elig_vec[s] = !oneshot_en || !in_wheel(slot_t'(s), prio_split) ||
                         (target == slot_t'(s));
  end
endmodule

// File: rtl/soc_pending_bank.sv
module soc_pending_bank
  import adc_soc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slot_vec_t trig_vec,
  input  slot_vec_t elig_vec,
  input  slot_vec_t grant_clr,
  output slot_vec_t pending_q,
  output slot_vec_t overflow_q,
  output slot_vec_t accept_vec
);
  slot_vec_t kept, ovf_set, pend_d;

  always_comb begin
    kept       = pending_q & ~grant_clr;
    accept_vec = trig_vec & elig_vec;
    ovf_set    = accept_vec & kept;
    pend_d     = kept | accept_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= '0;
      overflow_q <= '0;
    end else begin
      pending_q  <= pend_d;
      overflow_q <= overflow_q | ovf_set;
    end
  end
endmodule

// File: rtl/soc_arbiter.sv
module soc_arbiter
  import adc_soc_pkg::*;
(
  input  slot_vec_t pending,
  input  prio_t     prio_split,
  input  slot_t     rr_ptr,
  output pick_t     pick
);
  pick_t hp, rr;
  assign hp   = prio_pick(pending, prio_split);
  assign rr   = rr_pick(pending, prio_split, rr_ptr);
  assign pick = hp.valid ? hp : rr;
endmodule

// File: rtl/adc_soc_sequencer.sv
module adc_soc_sequencer
  import adc_soc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        oneshot_en,
  input  logic [PRIO_W-1:0]           prio_split,
  input  logic [SOC_SLOTS*SEL_W-1:0]  cfg_trig_sel,
  input  logic [SOC_SLOTS*CHAN_W-1:0] cfg_chan,
  input  logic [SOC_SLOTS-1:0]        cfg_simul,
  input  logic [SOC_SLOTS-1:0]        sw_force,
  input  logic [NUM_TIMERS-1:0]       timer_evt,
  input  logic                        ext_trig,
  input  logic [NUM_PWM-1:0]          pwm_soca,
  input  logic [NUM_PWM-1:0]          pwm_socb,
  input  logic [NUM_FB-1:0]           irq_fb,
  input  logic                        conv_done,
  output logic                        start_strobe,
  output logic [SLOT_W-1:0]           grant_slot,
  output logic [CHAN_W-1:0]           grant_chan,
  output logic                        grant_simul,
  output logic [SOC_SLOTS-1:0]        pending,
  output logic [SOC_SLOTS-1:0]        overflow,
  output logic [SLOT_W-1:0]           rr_ptr
);
  slot_vec_t trig_vec, elig_vec, accept_vec, grant_clr;
  slot_t     target;
  pick_t     pick;
  logic      busy_q, grant_fire;
  chan_t     pick_field;

  soc_trig_router u_router (
    .cfg_trig_sel (cfg_trig_sel),
    .sw_force     (sw_force),
    .timer_evt    (timer_evt),
    .ext_trig     (ext_trig),
    .pwm_soca     (pwm_soca),
    .pwm_socb     (pwm_socb),
    .irq_fb       (irq_fb),
    .trig_vec     (trig_vec)
  );

  soc_oneshot_gate u_gate (
    .oneshot_en (oneshot_en),
    .prio_split (prio_split),
    .rr_ptr     (rr_ptr),
    .cfg_simul  (cfg_simul),
    .target     (target),
    .elig_vec   (elig_vec)
  );

  soc_pending_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_vec   (trig_vec),
    .elig_vec   (elig_vec),
    .grant_clr  (grant_clr),
    .pending_q  (pending),
    .overflow_q (overflow),
    .accept_vec (accept_vec)
  );

  soc_arbiter u_arb (
    .pending    (pending),
    .prio_split (prio_split),
    .rr_ptr     (rr_ptr),
    .pick       (pick)
  );

  assign grant_fire = !busy_q && pick.valid;
  assign grant_clr  = grant_fire ? (slot_vec_t'(1) << pick.slot) : '0;
  assign pick_field = cfg_chan[pick.slot*CHAN_W +: CHAN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      start_strobe <= 1'b0;
      grant_slot   <= '0;
      grant_chan   <= '0;
      grant_simul  <= 1'b0;
      rr_ptr       <= slot_t'(SOC_SLOTS - 1);
    end else begin
      start_strobe <= grant_fire;
      if (grant_fire) begin
        busy_q      <= 1'b1;
        grant_slot  <= pick.slot;
        grant_chan  <= chan_out(pick_field, cfg_simul[pick.slot]);
        grant_simul <= cfg_simul[pick.slot];
        if (pick.wheel) rr_ptr <= pick.slot;
      end else if (conv_done) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_soc_sequencer_chk.sv
module adc_soc_sequencer_chk
  import adc_soc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      oneshot_en,
  input prio_t     prio_split,
  input logic      start_strobe,
  input slot_t     grant_slot,
  input chan_t     grant_chan,
  input logic      grant_simul,
  input slot_vec_t pending,
  input slot_vec_t overflow,
  input slot_t     rr_ptr,
  input logic      busy_q,
  input slot_vec_t accept_vec
);
  slot_vec_t wheel_mask;
  for (genvar s = 0; s < SOC_SLOTS; s++) begin : g_mask
    assign wheel_mask[s] = in_wheel(slot_t'(s), prio_split);
  end

  // R7
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |=> !start_strobe);
  // R7
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> !$past(busy_q));
  // R11
  strobe_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> |(($past(pending) >> grant_slot) & slot_vec_t'(1)));
  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overflow) & ~overflow) == '0);
  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_strobe |-> $stable(rr_ptr));
  // R6
  pair_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_strobe && grant_simul) |-> !grant_chan[CHAN_W-1]);
  // R8
  oneshot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_en |-> $onehot0(accept_vec & wheel_mask));
endmodule

bind adc_soc_sequencer adc_soc_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .oneshot_en   (oneshot_en),
  .prio_split   (prio_split),
  .start_strobe (start_strobe),
  .grant_slot   (grant_slot),
  .grant_chan   (grant_chan),
  .grant_simul  (grant_simul),
  .pending      (pending),
  .overflow     (overflow),
  .rr_ptr       (rr_ptr),
  .busy_q       (busy_q),
  .accept_vec   (accept_vec)
);

// File: tb/tb_adc_soc_sequencer.sv
module tb_adc_soc_sequencer;
  import adc_soc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NS = SOC_SLOTS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic oneshot_en;
  logic [PRIO_W-1:0] prio_split;
  logic [NS*SEL_W-1:0] cfg_trig_sel;
  logic [NS*CHAN_W-1:0] cfg_chan;
  logic [NS-1:0] cfg_simul, sw_force;
  logic [NUM_TIMERS-1:0] timer_evt;
  logic ext_trig;
  logic [NUM_PWM-1:0] pwm_soca, pwm_socb;
  logic [NUM_FB-1:0] irq_fb;
  logic conv_done;
  logic start_strobe, grant_simul;
  logic [SLOT_W-1:0] grant_slot, rr_ptr;
  logic [CHAN_W-1:0] grant_chan;
  logic [NS-1:0] pending, overflow;

  int vectors = 0, fails = 0;
  int m_ptr, m_gslot;
  logic [NS-1:0] m_pend, m_ovf;
  bit m_busy, m_strobe, m_gsimul;
  logic [CHAN_W-1:0] m_gchan;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_soc_sequencer dut (.*);

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit src_hit(int sel);
    if (sel >= 1 && sel <= 3) return timer_evt[sel-1];
    if (sel == 4) return ext_trig;
    if (sel >= 5 && sel <= 22) return ((sel - 5) % 2 == 1) ? pwm_socb[(sel-5)/2] : pwm_soca[(sel-5)/2];
    if (sel == 23 || sel == 24) return irq_fb[sel-23];
    return 1'b0;
  endfunction

  // walk to the next wheel slot (R8)
  function automatic int wstep(int p, int split);
    int x = p + 1;
    if (x >= NS || x < split) x = split;
    return x;
  endfunction

  task automatic step();
    int split = int'(prio_split);
    int tgt, win;
    bit wheel_win;
    logic [NS-1:0] trig, acc, clr;
    tgt = wstep(m_ptr, split);
    if (cfg_simul[m_ptr]) tgt = wstep(tgt, split);
    win = -1; wheel_win = 0;
    for (int s = 0; s < split && s < NS; s++) if (win < 0 && m_pend[s]) win = s;
    if (win < 0)
      for (int i = 1; i <= NS; i++) begin
        int idx = (m_ptr + i) % NS;
        if (win < 0 && idx >= split && m_pend[idx]) begin win = idx; wheel_win = 1; end
      end
    clr = '0;
    m_strobe = 0;
    if (!m_busy && win >= 0) begin
      clr[win] = 1'b1;
      m_strobe = 1;
    end
    for (int s = 0; s < NS; s++) begin
      trig[s] = sw_force[s] | src_hit(int'(cfg_trig_sel[s*SEL_W +: SEL_W]));
      acc[s] = trig[s] && (!oneshot_en || s < split || s == tgt);
    end
    m_ovf  = m_ovf | (acc & m_pend & ~clr);
    m_pend = (m_pend & ~clr) | acc;
    if (m_strobe) begin
      m_busy = 1; m_gslot = win;
      m_gsimul = cfg_simul[win];
      m_gchan = cfg_chan[win*CHAN_W +: CHAN_W];
      if (m_gsimul) m_gchan[CHAN_W-1] = 1'b0;
      if (wheel_win) m_ptr = win;
    end else if (conv_done && m_busy) m_busy = 0;
    @(posedge clk); @(negedge clk);
    chk("R7 strobe", start_strobe, m_strobe);
    chk("R2 pending", pending, m_pend);
    chk("R3 overflow", overflow, m_ovf);
    chk("R5 pointer", rr_ptr, m_ptr);
    if (m_strobe) begin
      chk("R4 grant slot", grant_slot, m_gslot);
      chk("R6 channel", grant_chan, m_gchan);
      chk("R6 pair flag", grant_simul, m_gsimul);
    end
  endtask

  task automatic quiet();
    sw_force = '0; timer_evt = '0; ext_trig = 0; pwm_soca = '0; pwm_socb = '0;
    irq_fb = '0; conv_done = 0;
  endtask

  task automatic rnd_inputs();
    for (int s = 0; s < NS; s++) sw_force[s] = ($urandom_range(0, 31) == 0);
    for (int k = 0; k < NUM_TIMERS; k++) timer_evt[k] = ($urandom_range(0, 15) == 0);
    for (int k = 0; k < NUM_PWM; k++) begin
      pwm_soca[k] = ($urandom_range(0, 15) == 0);
      pwm_socb[k] = ($urandom_range(0, 15) == 0);
    end
    for (int k = 0; k < NUM_FB; k++) irq_fb[k] = ($urandom_range(0, 15) == 0);
    ext_trig = ($urandom_range(0, 15) == 0);
    conv_done = ($urandom_range(0, 3) == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    quiet();
    oneshot_en = 1; prio_split = 5'd4;
    cfg_trig_sel = '1; cfg_chan = '0; cfg_simul = '0;
    cfg_simul[4] = 1'b1; cfg_chan[4*CHAN_W +: CHAN_W] = 4'hB;
    m_ptr = NS - 1; m_pend = '0; m_ovf = '0; m_busy = 0; m_strobe = 0;
    m_gslot = 0; m_gchan = '0; m_gsimul = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pending", pending, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 strobe", start_strobe, 0);
    chk("R1 pointer", rr_ptr, 15);
    rst_n = 1;
    // R8 slot 7 not target (target 4), R10 slot 1 high priority
    sw_force = 16'h0082; step(); quiet();
    chk("R8 R10 pending", pending, 16'h0002);
    step();
    chk("R4 strobe", start_strobe, 1);
    chk("R4 slot", grant_slot, 1);
    chk("R5 ptr held", rr_ptr, 15);
    conv_done = 1; step(); quiet();
    sw_force = 16'h0010; step(); quiet();
    step();
    chk("R5 ptr moved", rr_ptr, 4);
    chk("R6 pair chan", grant_chan, 3);
    conv_done = 1; step(); quiet();
    // R9 slot 4 simultaneous, target is 6
    sw_force = 16'h0060; step(); quiet();
    chk("R9 pending", pending, 16'h0040);
    // R11 retrigger at grant edge relatches
    sw_force = 16'h0040; step(); quiet();
    chk("R11 pending", pending, 16'h0040);
    chk("R11 overflow", overflow, 0);
    oneshot_en = 0; sw_force = 16'h0040; step(); quiet();
    chk("R3 overflow", overflow, 16'h0040);
    conv_done = 1; step(); quiet();
    // R2 source encodings under random configurations
    for (int ph = 0; ph < 8; ph++) begin
      prio_split = 5'($urandom_range(0, 16));
      oneshot_en = ($urandom_range(0, 1) == 1);
      for (int s = 0; s < NS; s++) begin
        cfg_trig_sel[s*SEL_W +: SEL_W] = 5'($urandom_range(0, 27));
        cfg_chan[s*CHAN_W +: CHAN_W] = 4'($urandom_range(0, 15));
        cfg_simul[s] = ($urandom_range(0, 3) == 0);
      end
      for (int c = 0; c < 2500; c++) begin
        rnd_inputs();
        step();
      end
      quiet();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule